// File: doc/BRIEF.md
# Configurable UART Receive Deframer

This block watches an asynchronous serial input line and turns each incoming character frame into a stored data word. Timing comes from a single-cycle oversampling pulse supplied from outside, sixteen pulses per bit by default. The input line is brought into the clock domain through two flops. A falling level starts a frame, and the start bit is confirmed at its middle. Data bits are then taken at their centres, least significant bit first. An optional parity bit follows, and the first stop bit is checked last.

The frame shape is set by static configuration inputs:
- the data length, five to eight bits;
- whether a parity bit is present;
- even or odd parity;
- stick parity, where the parity bit is a fixed value.

Each finished word is stored together with a parity-error flag and a framing-error flag. The store is either a single holding slot or a small FIFO, chosen by a mode input. A word that finds the store full is dropped and raises a sticky overrun flag. The receiver only works while both the global enable and the receive enable are high.

Top module: `uart_rx_deframer`

## Requirements
- R1: `word_len` selects the number of data bits: 2'b00, 2'b01, 2'b10 and 2'b11 select 5, 6, 7 and 8 bits. The word appears right-aligned on `rd_data`, with the unused upper bits zero.
- R2: A low line in idle is confirmed as a start bit only if it is still low 8 oversampling pulses later. A shorter low pulse stores no word, and the receiver returns to idle.
- R3: Data bits are sampled at their centres, 16 pulses apart, and are assembled least significant bit first.
- R4: With `par_on` low, no parity bit is expected. The bit after the data is the stop bit, and `rd_perr` is always 0.
- R5: With `par_on` high and `par_fixed` low, the parity check depends on `par_even`. When `par_even` is 1, the count of ones in the data bits plus the parity bit must be even. When `par_even` is 0, that count must be odd. A mismatch stores the word with `rd_perr` set to 1.
- R6: With `par_on` and `par_fixed` both high, the received parity bit must equal the inverse of `par_even`. Any other value sets `rd_perr`.
- R7: A low level at the centre of the first stop bit stores the word with `rd_ferr` set to 1. A high level stores it with `rd_ferr` set to 0.
- R8: Frames are received only while both `uart_on` and `rx_on` are high. Otherwise the line is ignored and nothing is stored.
- R9: With `fifo_on` low, the store holds one word, and `rx_full` is high while that word is held.
- R10: With `fifo_on` high, the store holds up to DEPTH words and returns them in arrival order. `rx_full` is high at DEPTH words.
- R11: A word that completes while the store is full is discarded. `rx_ovr` is then set and stays set until reset.
- R12: After reset, `rx_avail`, `rx_full` and `rx_ovr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling pulse, one cycle wide, OSR pulses per bit |
| rxd | input | 1 | Asynchronous serial input, idle high |
| uart_on | input | 1 | Global enable |
| rx_on | input | 1 | Receive enable |
| fifo_on | input | 1 | 1: FIFO of DEPTH words, 0: single holding slot |
| word_len | input | 2 | Data length code (5 to 8 bits) |
| par_on | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even (1) or odd (0) parity select |
| par_fixed | input | 1 | Stick parity select |
| rd_en | input | 1 | Remove the oldest stored word |
| rx_avail | output | 1 | At least one word is stored |
| rx_full | output | 1 | Store is full for the current mode |
| rx_ovr | output | 1 | Sticky overrun flag |
| rd_data | output | 8 | Oldest stored word |
| rd_perr | output | 1 | Parity error flag of the oldest word |
| rd_ferr | output | 1 | Framing error flag of the oldest word |

## Verification
The bench builds the block with OSR=16 and DEPTH=4. A four-entry FIFO can be filled in four frames, so the full boundary and a discarded fifth word are reached in a short run. The sixteen-pulse bit lets the bench drive whole bits on pulse boundaries. It can also cut a start bit short of its 8-pulse centre to exercise start confirmation. All four length codes, every parity mode with correct and flipped parity bits, and a low stop bit are each sent through the same scoreboard.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_word_t;

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       active,
    input  logic [1:0] word_len,
    input  logic       par_on,
    input  logic       par_even,
    input  logic       par_fixed,
    output logic       w_valid,
    output rx_word_t   w_word
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);

    typedef struct packed {
        rx_state_e  st;
        logic [CW-1:0] cnt;
        logic [2:0] idx;
        logic [7:0] sh;
        logic       pbit;
        logic [1:0] sync;
    } samp_t;

    samp_t s_d, s_q;

    logic       line;
    logic [2:0] last_idx;
    logic [7:0] data_al;
    logic       exp_par;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], rxd};
        line     = s_q.sync[1];
        last_idx = 3'd4 + {1'b0, word_len};
        data_al  = s_q.sh >> (~word_len);
        exp_par  = par_fixed ? ~par_even : (par_even ? ^data_al : ~^data_al);
        w_valid  = 1'b0;
        w_word   = '{data: data_al, perr: par_on & (s_q.pbit != exp_par), ferr: ~line};

        if (!active) begin
            s_d.st  = ST_IDLE;
            s_d.cnt = '0;
        end else if (os_tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
            unique case (s_q.st)
                ST_IDLE: begin
                    s_d.cnt = '0;
                    if (!line) s_d.st = ST_START;
                end
                ST_START: begin
                    if (s_q.cnt == MID_CNT) begin
                        s_d.cnt = '0;
                        s_d.idx = '0;
                        s_d.st  = line ? ST_IDLE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.sh  = {line, s_q.sh[7:1]};
                        s_d.idx = s_q.idx + 1'b1;
                        if (s_q.idx == last_idx) s_d.st = par_on ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.pbit = line;
                        s_d.st   = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (s_q.cnt == LAST_CNT) begin
                        w_valid = 1'b1;
                        s_d.st  = ST_IDLE;
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: '0, idx: '0, sh: '0, pbit: 1'b0, sync: 2'b11};
        end else begin
            s_q <= s_d;
        end
    end

    // R8
    gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> s_q.st == ST_IDLE);

    // R3
    word_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> (os_tick && active));

    // R2
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && os_tick && s_q.st == ST_START && s_q.cnt == MID_CNT && line)
        |=> s_q.st == ST_IDLE);

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fifo_on,
    input  logic     w_valid,
    input  rx_word_t w_word,
    input  logic     rd_en,
    output logic     avail,
    output logic     full,
    output logic     ovr,
    output rx_word_t head
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP      = CW'(DEPTH);

    typedef struct packed {
        rx_word_t [DEPTH-1:0] mem;
        logic [AW-1:0]        wp;
        logic [AW-1:0]        rp;
        logic [CW-1:0]        cnt;
        logic                 ovr;
    } buf_t;

    buf_t b_d, b_q;
    logic push, pop;

    always_comb begin
        b_d   = b_q;
        avail = (b_q.cnt != '0);
        full  = fifo_on ? (b_q.cnt == CAP) : avail;
        pop   = rd_en && avail;
        push  = w_valid && !full;
        head  = b_q.mem[b_q.rp];
        ovr   = b_q.ovr;

        if (w_valid && full) b_d.ovr = 1'b1;
        if (push) begin
            b_d.mem[b_q.wp] = w_word;
            b_d.wp = (b_q.wp == LAST_PTR) ? '0 : b_q.wp + 1'b1;
        end
        if (pop) b_d.rp = (b_q.rp == LAST_PTR) ? '0 : b_q.rp + 1'b1;
        if (push && !pop)      b_d.cnt = b_q.cnt + 1'b1;
        else if (pop && !push) b_d.cnt = b_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_q.cnt <= CAP);

    // R9
    single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_on && avail && w_valid && !rd_en) |=> b_q.cnt == $past(b_q.cnt));

    // R11
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_q.ovr |=> b_q.ovr);

    // R11
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && full) |=> (b_q.ovr && b_q.cnt == $past(b_q.cnt) - CW'(rd_en)));

endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       uart_on,
    input  logic       rx_on,
    input  logic       fifo_on,
    input  logic [1:0] word_len,
    input  logic       par_on,
    input  logic       par_even,
    input  logic       par_fixed,
    input  logic       rd_en,
    output logic       rx_avail,
    output logic       rx_full,
    output logic       rx_ovr,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr
);

    logic     active;
    logic     w_valid;
    rx_word_t w_word;
    rx_word_t head;

    assign active = uart_on & rx_on;

    uart_rx_sampler #(.OSR(OSR)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .active    (active),
        .word_len  (word_len),
        .par_on    (par_on),
        .par_even  (par_even),
        .par_fixed (par_fixed),
        .w_valid   (w_valid),
        .w_word    (w_word)
    );

    uart_rx_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_on (fifo_on),
        .w_valid (w_valid),
        .w_word  (w_word),
        .rd_en   (rd_en),
        .avail   (rx_avail),
        .full    (rx_full),
        .ovr     (rx_ovr),
        .head    (head)
    );

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;

    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_avail && word_len == 2'b00) |-> rd_data[7:5] == 3'b000);

endmodule

// File: tb/uart_rx_deframer_tb.sv
module uart_rx_deframer_tb;

    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic rxd = 1'b1;
    logic uart_on = 1'b1, rx_on = 1'b1, fifo_on = 1'b1;
    logic [1:0] word_len = 2'b11;
    logic par_on = 1'b0, par_even = 1'b0, par_fixed = 1'b0;
    logic rd_en = 1'b0;
    logic rx_avail, rx_full, rx_ovr, rd_perr, rd_ferr;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    logic [1:0] tdiv = '0;
    bit auto_pop = 1'b1;
    bit man_pop = 1'b0;
    logic [9:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tdiv <= tdiv + 1'b1;
        os_tick <= (tdiv == 2'd3);
    end

    uart_rx_deframer #(.OSR(16), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .uart_on(uart_on), .rx_on(rx_on), .fifo_on(fifo_on),
        .word_len(word_len), .par_on(par_on), .par_even(par_even),
        .par_fixed(par_fixed), .rd_en(rd_en), .rx_avail(rx_avail),
        .rx_full(rx_full), .rx_ovr(rx_ovr), .rd_data(rd_data),
        .rd_perr(rd_perr), .rd_ferr(rd_ferr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard pop and compare, plus manual pops
    always @(negedge clk) begin
        if (rd_en) begin
            rd_en = 1'b0;
        end else if (man_pop) begin
            rd_en = 1'b1;
            man_pop = 1'b0;
        end else if (auto_pop && rx_avail) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected word", {22'd0, rd_data, rd_perr, rd_ferr}, 32'hFFFF_FFFF);
            end else begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {22'd0, rd_data, rd_perr, rd_ferr}, {22'd0, e});
            end
            rd_en = 1'b1;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!os_tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit flip_par, input bit stop_v,
                        input bit expect_it, input string tag);
        int nb;
        logic [7:0] dm;
        logic p;
        nb = 5 + int'(word_len);
        dm = d & 8'((1 << nb) - 1);
        p = par_fixed ? ~par_even : (par_even ? ^dm : ~^dm);
        if (flip_par) p = ~p;
        @(negedge clk);
        rxd = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < nb; i++) begin
            rxd = dm[i];
            wait_ticks(16);
        end
        if (par_on) begin
            rxd = p;
            wait_ticks(16);
        end
        rxd = stop_v;
        if (expect_it) begin
            exp_q.push_back({dm, flip_par & par_on, ~stop_v});
            tag_q.push_back(tag);
        end
        wait_ticks(16);
        rxd = 1'b1;
        wait_ticks(stop_v ? 2 : 18);
    endtask

    task automatic drain(input string tag);
        int lim = 0;
        while (exp_q.size() != 0 && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        repeat (8) @(negedge clk);
        chk(tag, exp_q.size(), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic man_check(input string tag, input logic [7:0] d, input bit pe, input bit fe);
        chk(tag, {29'd0, rx_avail, rd_perr, rd_ferr}, {29'd0, 1'b1, pe, fe});
        chk(tag, {24'd0, rd_data}, {24'd0, d});
        man_pop = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(20 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R12
        chk("R12 reset flags", {29'd0, rx_avail, rx_full, rx_ovr}, 32'd0);

        // R3 R4: 8 data bits, no parity
        send(8'hA5, 0, 1, 1, "R3 8N1 A5");
        send(8'h3C, 0, 1, 1, "R3 8N1 3C");
        send(8'h00, 0, 1, 1, "R4 8N1 00");
        send(8'hFF, 0, 1, 1, "R4 8N1 FF");
        drain("R3 drain");

        // R1: shorter lengths
        word_len = 2'b00; send(8'hF5, 0, 1, 1, "R1 5-bit");
        word_len = 2'b01; send(8'hEA, 0, 1, 1, "R1 6-bit");
        word_len = 2'b10; send(8'hD3, 0, 1, 1, "R1 7-bit");
        drain("R1 drain");

        // R5: normal parity
        word_len = 2'b11; par_on = 1'b1;
        par_even = 1'b1; send(8'h37, 0, 1, 1, "R5 even ok");
        send(8'h37, 1, 1, 1, "R5 even bad");
        par_even = 1'b0; send(8'h81, 0, 1, 1, "R5 odd ok");
        send(8'h81, 1, 1, 1, "R5 odd bad");
        word_len = 2'b00; send(8'h13, 1, 1, 1, "R5 odd bad 5-bit");
        drain("R5 drain");

        // R6: stick parity
        word_len = 2'b11; par_fixed = 1'b1;
        par_even = 1'b0; send(8'h5A, 0, 1, 1, "R6 stick one ok");
        send(8'h5A, 1, 1, 1, "R6 stick one bad");
        par_even = 1'b1; send(8'h5B, 0, 1, 1, "R6 stick zero ok");
        send(8'h5B, 1, 1, 1, "R6 stick zero bad");
        drain("R6 drain");
        par_fixed = 1'b0; par_on = 1'b0;

        // R7: framing error
        send(8'h6E, 0, 0, 1, "R7 low stop");
        send(8'h6F, 0, 1, 1, "R7 good after low stop");
        drain("R7 drain");

        // R2: short low pulse
        @(negedge clk); rxd = 1'b0;
        wait_ticks(3);
        rxd = 1'b1;
        wait_ticks(40);
        chk("R2 glitch stores nothing", {31'd0, rx_avail}, 32'd0);
        send(8'h42, 0, 1, 1, "R2 frame after glitch");
        drain("R2 drain");

        // R8: enables
        uart_on = 1'b0; send(8'h99, 0, 1, 0, "");
        chk("R8 global off", {31'd0, rx_avail}, 32'd0);
        uart_on = 1'b1; rx_on = 1'b0; send(8'h98, 0, 1, 0, "");
        chk("R8 rx off", {31'd0, rx_avail}, 32'd0);
        rx_on = 1'b1;

        // R9 R11: single holding slot
        auto_pop = 1'b0; fifo_on = 1'b0;
        send(8'h11, 0, 1, 0, "");
        chk("R9 full after one", {30'd0, rx_full, rx_ovr}, 32'd2);
        send(8'h22, 0, 1, 0, "");
        chk("R11 overrun set", {31'd0, rx_ovr}, 32'd1);
        man_check("R9 held word kept", 8'h11, 0, 0);
        chk("R9 empty after pop", {31'd0, rx_avail}, 32'd0);
        chk("R11 overrun sticky", {31'd0, rx_ovr}, 32'd1);

        // R10 R11: FIFO mode
        do_reset();
        fifo_on = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            send(8'h30 + 8'(i), 0, 1, 0, "");
            chk("R10 not full early", {30'd0, rx_full, rx_ovr}, (i == DEPTH - 1) ? 32'd2 : 32'd0);
        end
        send(8'hEE, 0, 1, 0, "");
        chk("R11 fifo overrun", {31'd0, rx_ovr}, 32'd1);
        for (int i = 0; i < DEPTH; i++) begin
            man_check("R10 fifo order", 8'h30 + 8'(i), 0, 0);
        end
        chk("R10 empty at end", {30'd0, rx_avail, rx_full}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule